// File: doc/BRIEF.md
# OTP Byte Memory Pin-Mode Controller

This block sits on the device side of a one-time-programmable byte memory. It samples three active-low control pins (chip enable, output enable and program strobe) on a system clock and decodes them into operating modes. The modes are read/verify, output off, standby, page load, page programming, single-byte programming and an idle state in which programming is inhibited. The memory contents are held in an internal register-array model. A programming write can only turn bits from one to zero, as in cells that leave the factory blank (all ones).

Software or a tester drives the pins. For a single byte it presents the address and data with chip enable low and output enable high, then pulses the program strobe low. The write happens when the strobe returns high. For a page it first loads up to four address/data pairs into a page buffer (chip enable high, output enable low, strobe high). The lane is picked by the two low address bits. One strobe pulse with both enables high then burns all four lanes into the page that the upper address bits name, and the buffer is emptied. The data bus is split into a drive value and a drive-enable, so several devices can share one bus by output-enable control.

Top module: `otp_pin_ctrl`

## Requirements
- R1: With ce_n=0 and oe_n=0, data_oe is 1 and data_out equals the byte stored at addr, combinationally in the same cycle.
- R2: With oe_n=1, data_oe is 0.
- R3: With ce_n=1, data_oe is 0 for either level of oe_n.
- R4: At a clock edge where ce_n=1, pgm_n=1 and oe_n=0, data_in is stored into page lane addr[1:0]. A later load to the same lane overwrites it.
- R5: A strobe rise is a clock edge where pgm_n=1 after pgm_n=0 at the previous edge. A strobe rise with ce_n=1 and oe_n=1 ANDs page lane k into the byte at {addr[5:2], k} for k=0..3. It then returns every lane to all ones, so lanes not loaded since the last page write change nothing.
- R6: A strobe rise with ce_n=0 and oe_n=1 ANDs data_in into the byte at addr.
- R7: A read with pgm_n=1 (verify) issued in the cycle after a write shows the updated byte.
- R8: While pgm_n stays high, no stored byte changes, whatever ce_n, oe_n, addr and data_in do.
- R9: Programming only clears bits: the new byte is the old byte AND the written value.
- R10: After synchronous reset (rst_n=0), every byte reads 0xFF, every page lane is all ones, and the strobe is treated as high.
- R11: A strobe rise with oe_n=0 writes nothing into the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| addr | input | 6 | Byte address |
| data_in | input | 8 | Data bus value seen by the device |
| data_out | output | 8 | Value to drive onto the data bus |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The assertions assume that the pins are synchronous to clk and hold steady between edges. They also assume that a strobe pulse spans at least one sampled edge, since a low level seen at no edge is not a pulse to this block. The bench changes every pin one time unit after the rising edge and holds it for whole cycles. In its random phase, the pins change only at cycle boundaries, so each low strobe level lasts one or more sampled edges. A behavioural model with its own arrays tracks the expected contents and is compared on every falling edge.

// File: rtl/otp_pin_pkg.sv
// Package: shared mode encoding and pin decode for the OTP pin-mode controller.
// Assumes pins are already synchronous to the block clock.
package otp_pin_pkg;

    typedef enum logic [2:0] {
        OPM_STANDBY,
        OPM_READ,
        OPM_OUT_OFF,
        OPM_PAGE_LOAD,
        OPM_PAGE_PULSE,
        OPM_BYTE_PULSE
    } otp_mode_e;

    // Level decode of the three active-low control pins.
    function automatic otp_mode_e otp_decode(input logic ce_n, input logic oe_n, input logic pgm_n);
        otp_mode_e m;
        if (ce_n) begin
            if (!oe_n && pgm_n)      m = OPM_PAGE_LOAD;
            else if (oe_n && !pgm_n) m = OPM_PAGE_PULSE;
            else                     m = OPM_STANDBY;
        end else begin
            if (!oe_n)               m = OPM_READ;
            else if (!pgm_n)         m = OPM_BYTE_PULSE;
            else                     m = OPM_OUT_OFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
// Module: decodes pin levels into bus drive, page load and commit strobes.
// Commits fire on the clock edge where pgm_n is seen high after a low sample.
// Assumes a strobe pulse spans at least one sampled clock edge.
module otp_mode_decode
    import otp_pin_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      pgm_n,
    output otp_mode_e mode,
    output logic      drive_en,
    output logic      load_en,
    output logic      page_we,
    output logic      byte_we
);

    logic pgm_q;
    logic strobe_rise;

    // Remember the strobe level of the previous edge; reset treats it as high.
    always_ff @(posedge clk) begin
        if (!rst_n) pgm_q <= 1'b1;
        else        pgm_q <= pgm_n;
    end

    // Mode and strobe decode.
    always_comb begin
        mode        = otp_decode(ce_n, oe_n, pgm_n);
        strobe_rise = !pgm_q && pgm_n;
        drive_en    = (mode == OPM_READ);
        load_en     = (mode == OPM_PAGE_LOAD);
        page_we     = strobe_rise && ce_n && oe_n;
        byte_we     = strobe_rise && !ce_n && oe_n;
    end

    // R2: output enable high keeps the bus released
    a_r2_oe_high_release: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !drive_en);
    // R3: standby releases the bus regardless of output enable
    a_r3_standby_release: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !drive_en);
    // R8: a strobe held high across two edges yields no write
    a_r8_held_high_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_n && $past(pgm_n)) |-> !(page_we || byte_we));
    // R11: no write while output enable is low
    a_r11_oe_low_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !(page_we || byte_we));
    // Writes are mutually exclusive
    a_r5_r6_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(page_we && byte_we));

endmodule

// File: rtl/otp_page_latch.sv
// Module: page buffer of 2**PAGE_W lanes, each DATA_W bits wide.
// Lanes reset and clear to all ones so an unloaded lane is neutral
// in an AND-style program. A clear takes priority over a load.
module otp_page_latch #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 2,
    localparam int PAGE_N = 1 << PAGE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [PAGE_W-1:0]        sel,
    input  logic [DATA_W-1:0]        din,
    input  logic                     clear,
    output logic [PAGE_N*DATA_W-1:0] lanes
);

    for (genvar k = 0; k < PAGE_N; k++) begin : g_lane
        logic [DATA_W-1:0] ent;

        // Hold one lane: load on selection, return to ones on clear or reset.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                         ent <= '1;
            else if (load && sel == PAGE_W'(k))          ent <= din;
        end

        assign lanes[k*DATA_W +: DATA_W] = ent;

        // R4: a selected load captures the data present at that edge
        a_r4_lane_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (load && !clear && sel == PAGE_W'(k)) |=> ent == $past(din));
        // R5: lane empty after a page commit
        a_r5_lane_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> ent == '1);
    end

endmodule

// File: rtl/otp_cell_array.sv
// Module: register-array model of 2**ADDR_W one-time-programmable bytes.
// Programming ANDs new data into a word; only a reset restores ones
// (a blank part at power-on). Read is asynchronous on addr.
module otp_cell_array #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int PAGE_W = 2,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PAGE_N = 1 << PAGE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     page_we,
    input  logic                     byte_we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        din,
    input  logic [PAGE_N*DATA_W-1:0] lanes,
    output logic [DATA_W-1:0]        rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic              page_hit;
        logic              byte_hit;
        logic [DATA_W-1:0] page_mask;
        logic [DATA_W-1:0] byte_mask;

        // Select which write masks apply to this word.
        always_comb begin
            page_hit  = page_we && (addr[ADDR_W-1:PAGE_W] == (ADDR_W-PAGE_W)'(i >> PAGE_W));
            byte_hit  = byte_we && (addr == ADDR_W'(i));
            page_mask = page_hit ? lanes[(i % PAGE_N)*DATA_W +: DATA_W] : '1;
            byte_mask = byte_hit ? din : '1;
        end

        // Store the word; programming can only clear bits.
        always_ff @(posedge clk) begin
            if (!rst_n) cells[i] <= '1;
            else        cells[i] <= cells[i] & page_mask & byte_mask;
        end

        // R9: no bit of a word ever goes from zero to one
        a_r9_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ((cells[i] & $past(cells[i])) == cells[i]));
        // R8: without a write strobe the word holds
        a_r8_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!page_we && !byte_we) |=> $stable(cells[i]));
    end

    assign rd_data = cells[addr];

endmodule

// File: rtl/otp_pin_ctrl.sv
// Module: top of the OTP pin-mode controller. Joins the pin decoder,
// the page buffer and the cell array, and presents the data bus as a
// drive value plus enable. Assumes synchronous pins.
module otp_pin_ctrl #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int PAGE_W = 2,
    localparam int PAGE_N = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    import otp_pin_pkg::*;

    otp_mode_e                mode;
    logic                     drive_en;
    logic                     load_en;
    logic                     page_we;
    logic                     byte_we;
    logic [PAGE_N*DATA_W-1:0] lanes;
    logic [DATA_W-1:0]        rd_data;

    otp_mode_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .pgm_n    (pgm_n),
        .mode     (mode),
        .drive_en (drive_en),
        .load_en  (load_en),
        .page_we  (page_we),
        .byte_we  (byte_we)
    );

    otp_page_latch #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_en),
        .sel   (addr[PAGE_W-1:0]),
        .din   (data_in),
        .clear (page_we),
        .lanes (lanes)
    );

    otp_cell_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .page_we (page_we),
        .byte_we (byte_we),
        .addr    (addr),
        .din     (data_in),
        .lanes   (lanes),
        .rd_data (rd_data)
    );

    // Bus outputs.
    always_comb begin
        data_oe  = drive_en;
        data_out = rd_data;
    end

    // R1: a read cycle always drives the bus
    a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |-> data_oe);
    // R7: mode consistent with driving
    a_r7_drive_mode: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (mode == OPM_READ));

endmodule

// File: tb/test_otp_pin_ctrl.sv
`timescale 1ns/100ps
module test_otp_pin_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [64];
    logic [7:0] ref_page [4];
    logic       ref_pgm_prev;

    always #2.5 clk = ~clk;

    otp_pin_ctrl i_otp_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: updated at each rising edge from the pin levels.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) ref_mem[i] = 8'hFF;
            for (int k = 0; k < 4; k++) ref_page[k] = 8'hFF;
            ref_pgm_prev = 1'b1;
        end else begin
            if (!ref_pgm_prev && pgm_n && ce_n && oe_n) begin
                for (int k = 0; k < 4; k++) begin
                    ref_mem[{addr[5:2], 2'(k)}] = ref_mem[{addr[5:2], 2'(k)}] & ref_page[k];
                    ref_page[k] = 8'hFF;
                end
            end
            if (!ref_pgm_prev && pgm_n && !ce_n && oe_n)
                ref_mem[addr] = ref_mem[addr] & data_in;
            if (ce_n && pgm_n && !oe_n)
                ref_page[addr[1:0]] = data_in;
            ref_pgm_prev = pgm_n;
        end
    end

    // Per-cycle comparison against the model, half a cycle from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ce_n)      check("R3", data_oe, 0);
            else if (oe_n) check("R2", data_oe, 0);
            else begin
                check("R1", data_oe, 1);
                check(pgm_n ? "R7" : "R1", data_out, ref_mem[addr]);
            end
        end
    end

    task automatic step(input logic c, input logic o, input logic p,
                        input logic [5:0] a, input logic [7:0] d);
        ce_n = c; oe_n = o; pgm_n = p; addr = a; data_in = d;
        @(posedge clk); #1;
    endtask

    // Present a verify read and compare the bus immediately.
    task automatic read_exp(input logic [5:0] a, input logic [7:0] e, input string req);
        ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; addr = a;
        #0.5;
        check(req, data_oe, 1);
        check(req, data_out, e);
        @(posedge clk); #1;
    endtask

    task automatic byte_write(input logic [5:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, 1'b0, a, d);
        step(1'b0, 1'b1, 1'b1, a, d); // rise here
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: blank after reset
        for (int i = 0; i < 64; i++) read_exp(6'(i), 8'hFF, "R10");
        // R2 / R3: bus released
        step(1'b0, 1'b1, 1'b1, 6'd3, 8'h00); check("R2", data_oe, 0);
        step(1'b1, 1'b0, 1'b0, 6'd3, 8'h00); check("R3", data_oe, 0);
        step(1'b1, 1'b1, 1'b1, 6'd3, 8'h00); check("R3", data_oe, 0);
        // R6 / R7: byte write and verify
        byte_write(6'd5, 8'hA5);
        read_exp(6'd5, 8'hA5, "R6");
        // R9: AND of old and new
        byte_write(6'd5, 8'h3C);
        read_exp(6'd5, 8'h24, "R9");
        // R8: held strobe writes nothing
        for (int j = 0; j < 6; j++) step(1'(j & 1), 1'b1, 1'b1, 6'd5, 8'h00);
        read_exp(6'd5, 8'h24, "R8");
        // R4 / R5: page load with an overwrite, then page write
        step(1'b1, 1'b0, 1'b1, 6'd8,  8'h11);
        step(1'b1, 1'b0, 1'b1, 6'd9,  8'h22);
        step(1'b1, 1'b0, 1'b1, 6'd10, 8'h00);
        step(1'b1, 1'b0, 1'b1, 6'd10, 8'h33);
        step(1'b1, 1'b0, 1'b1, 6'd11, 8'h44);
        step(1'b1, 1'b1, 1'b0, 6'd8,  8'h00);
        step(1'b1, 1'b1, 1'b1, 6'd8,  8'h00);
        read_exp(6'd8,  8'h11, "R5");
        read_exp(6'd9,  8'h22, "R5");
        read_exp(6'd10, 8'h33, "R4");
        read_exp(6'd11, 8'h44, "R5");
        read_exp(6'd12, 8'hFF, "R5");
        // R5: empty buffer commit changes nothing
        step(1'b1, 1'b1, 1'b0, 6'd9, 8'h00);
        step(1'b1, 1'b1, 1'b1, 6'd9, 8'h00);
        read_exp(6'd9, 8'h22, "R5");
        // R5: partial page only touches the loaded lane
        step(1'b1, 1'b0, 1'b1, 6'd17, 8'h0F);
        step(1'b1, 1'b1, 1'b0, 6'd16, 8'h00);
        step(1'b1, 1'b1, 1'b1, 6'd16, 8'h00);
        read_exp(6'd16, 8'hFF, "R5");
        read_exp(6'd17, 8'h0F, "R5");
        // R11: strobe rise with oe_n low writes nothing
        step(1'b0, 1'b0, 1'b0, 6'd20, 8'h00);
        step(1'b0, 1'b0, 1'b1, 6'd20, 8'h00);
        read_exp(6'd20, 8'hFF, "R11");
        // Random phase, checked by the model every cycle.
        for (int j = 0; j < 3000; j++)
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 3) != 0), 6'($urandom_range(0, 63)),
                 8'($urandom_range(0, 255)));
        // R10: reset restores blank state
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b0, 6'd0, 8'h00);
        step(1'b1, 1'b1, 1'b0, 6'd0, 8'h00);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 1'b1, 6'd0, 8'h00);
        read_exp(6'd5, 8'hFF, "R10");
        read_exp(6'd8, 8'hFF, "R10");
        finish_run();
    end

endmodule